// File: doc/BRIEF.md
# Task Switch Commit Sequencer

This block runs the closing phase of a hardware task switch. After a start pulse it saves the outgoing task's context. It then marks the incoming task's descriptor busy, unless the switch is a return, and loads the task register with the incoming selector and descriptor. Next it fetches the incoming task's saved context, one 32-bit word per handshake, from a simple memory port. Last, it steps through a fixed number of segment descriptor qualification checks and ends the switch.

The sequence has a commit point, which is reached when the last context word has been fetched. A fault raised before the context load starts abandons the switch. In that case every register the block holds goes back to its value from before the start, in a single cycle. A fault raised during the context load ends the switch with "corrupt" status, and the words fetched so far stay in place. A fault raised during qualification does not cancel the switch. The remaining checks are skipped, the switch completes, and an exception request is raised with the loaded instruction pointer still in place, so the first instruction of the new task counts as not yet run.

Each run ends with a one-cycle `done` pulse that carries a 2-bit status.

Top module: `task_switch_seq`

## Requirements
- R1: A `start` pulse seen while `running` is low begins a switch, and `running` goes high on the next cycle. A `start` pulse seen while `running` is high is ignored: the selector, descriptor and cause of the switch in progress are the ones that take effect.
- R2: The cause is encoded as 0 call, 1 jump, 2 exception, 3 interrupt and 4 return. For causes 0 to 3, `busy_flag` is 1 after a successful switch. For cause 4, `busy_flag` keeps the `new_busy` value that was sampled at start.
- R3: The task register loads before the first context word is requested. After any switch that is not aborted, `tr_sel` and `tr_desc` equal the selector and descriptor that were sampled at start.
- R4: Context words are requested on `mem_valid` with `mem_idx` running 0, 1, … up to `CTX_WORDS-1`. The index moves on only after a cycle in which `mem_valid` and `mem_ready` are both high and `fault` is low. Word i lands in `ctx_out[i*32 +: 32]` only on such a completed handshake.
- R5: A `fault` during the save, busy-mark or task-register step ends the switch with status 1 (aborted). After that, `ctx_out`, `tr_sel`, `tr_desc` and `busy_flag` all hold their pre-start values, with `busy_flag` equal to the sampled `new_busy`.
- R6: A `fault` during the context load ends the switch with status 2 (corrupt). The words fetched before the faulting one keep their new values, the rest keep their old values, and the task register and busy flag stay updated.
- R7: A `fault` during qualification, while `committed` is high, skips the remaining checks. The switch then ends with status 3 and `exc_req` high in the same cycle as `done`. With no fault, status is 0 and `exc_req` stays low.
- R8: When status is 3, the instruction pointer word (word index 3, `IP_IDX`) of `ctx_out` equals the word fetched for index 3.
- R9: On every switch that is not aborted, `save_out` holds the `ctx_out` value from before the start.
- R10: `done` lasts exactly one cycle, and `running` is low while `done` is high.
- R11: After a synchronous reset (`rst_n` low at a clock edge), `running`, `committed`, `mem_valid`, `done`, `exc_req`, `busy_flag`, `tr_sel`, `tr_desc` and `ctx_out` are all 0, even if reset comes in the middle of a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a switch (honoured only when idle) |
| cause | input | 3 | Switch cause: 0 call, 1 jump, 2 exception, 3 interrupt, 4 return |
| new_sel | input | SEL_W | Incoming task selector |
| new_desc | input | DESC_W | Incoming task descriptor |
| new_busy | input | 1 | Current busy flag of the incoming descriptor |
| fault | input | 1 | Error raised by the step in progress |
| mem_valid | output | 1 | Context word request |
| mem_idx | output | IDX_W | Index of the requested word |
| mem_ready | input | 1 | Memory accepts the request and returns data |
| mem_data | input | WORD_W | Returned context word |
| running | output | 1 | A switch is in progress |
| committed | output | 1 | Past the commit point, qualifying |
| busy_flag | output | 1 | Busy flag of the incoming descriptor |
| tr_sel | output | SEL_W | Task register selector |
| tr_desc | output | DESC_W | Task register descriptor |
| ctx_out | output | CTX_WORDS*WORD_W | Architectural context, word i at bits i*WORD_W |
| save_out | output | CTX_WORDS*WORD_W | Saved context of the outgoing task |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 aborted, 2 corrupt, 3 committed with exception |
| exc_req | output | 1 | Exception request for the new task, with `done` |

## Verification
The commit point is where two functions can fall on the same cycle: a load fault and the handshake that completes the last context word. The bench raises `fault` in the cycle where `mem_valid` shows the final index while `mem_ready` is high. The expected result is a corrupt status with that last word still old and no exception, because the fault overrides the handshake. A second collision comes from a `start` pulse that arrives while a switch is running. It is judged by checking that the task register holds the first selector and not the second.

// File: rtl/tsw_pkg.sv
// Shared encodings for the task switch commit sequencer.
// Assumes: cause and status codes are fixed by the port contract.
package tsw_pkg;
    typedef enum logic [2:0] {
        CAUSE_CALL = 3'd0,
        CAUSE_JMP  = 3'd1,
        CAUSE_EXC  = 3'd2,
        CAUSE_INT  = 3'd3,
        CAUSE_RET  = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        STAT_OK      = 2'd0,
        STAT_ABORT   = 2'd1,
        STAT_CORRUPT = 2'd2,
        STAT_EXC     = 2'd3
    } status_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SAVE = 3'd1,
        PH_BUSY = 3'd2,
        PH_TR   = 3'd3,
        PH_LOAD = 3'd4,
        PH_QUAL = 3'd5
    } phase_e;
endpackage

// File: rtl/tsw_ctrl.sv
// Sequencing FSM: save, busy-mark, task-register load, context load,
// qualification. Produces strobes for the datapath units and the
// completion pulse with status.
// Assumes: fault applies to the step in progress; a fault overrides a
// memory handshake in the same cycle.
module tsw_ctrl
    import tsw_pkg::*;
#(
    parameter int CTX_WORDS = 18,
    parameter int QUAL_CNT  = 6,
    localparam int IDX_W    = $clog2(CTX_WORDS),
    localparam int Q_W      = $clog2(QUAL_CNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       cause,
    input  logic             fault,
    input  logic             mem_ready,
    output logic             running,
    output logic             committed,
    output logic             mem_valid,
    output logic [IDX_W-1:0] mem_idx,
    output logic             snap,
    output logic             save_en,
    output logic             busy_set,
    output logic             tr_load,
    output logic             ld_we,
    output logic             restore,
    output logic             done,
    output logic [1:0]       status,
    output logic             exc_req
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CTX_WORDS - 1);
    localparam logic [Q_W-1:0]   LAST_Q   = Q_W'(QUAL_CNT - 1);

    phase_e           phase_q;
    logic [2:0]       cause_q;
    logic [IDX_W-1:0] idx_q;
    logic [Q_W-1:0]   q_q;
    logic             pre_commit;

    // Decode per-phase strobes for the datapath.
    always_comb begin
        pre_commit = (phase_q == PH_SAVE) || (phase_q == PH_BUSY) || (phase_q == PH_TR);
        snap       = (phase_q == PH_IDLE) && start;
        save_en    = (phase_q == PH_SAVE) && !fault;
        busy_set   = (phase_q == PH_BUSY) && !fault && (cause_q != CAUSE_RET);
        tr_load    = (phase_q == PH_TR) && !fault;
        ld_we      = (phase_q == PH_LOAD) && mem_ready && !fault;
        restore    = pre_commit && fault;
        mem_valid  = (phase_q == PH_LOAD);
        mem_idx    = idx_q;
        running    = (phase_q != PH_IDLE);
        committed  = (phase_q == PH_QUAL);
    end

    // Phase transitions, word/check counters and completion reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cause_q <= 3'd0;
            idx_q   <= '0;
            q_q     <= '0;
            done    <= 1'b0;
            status  <= STAT_OK;
            exc_req <= 1'b0;
        end else begin
            done    <= 1'b0;
            exc_req <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        cause_q <= cause;
                        phase_q <= PH_SAVE;
                    end
                end
                PH_SAVE, PH_BUSY, PH_TR: begin
                    if (fault) begin
                        done    <= 1'b1;
                        status  <= STAT_ABORT;
                        phase_q <= PH_IDLE;
                    end else if (phase_q == PH_SAVE) begin
                        phase_q <= PH_BUSY;
                    end else if (phase_q == PH_BUSY) begin
                        phase_q <= PH_TR;
                    end else begin
                        idx_q   <= '0;
                        phase_q <= PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    if (fault) begin
                        done    <= 1'b1;
                        status  <= STAT_CORRUPT;
                        phase_q <= PH_IDLE;
                    end else if (mem_ready) begin
                        if (idx_q == LAST_IDX) begin
                            q_q     <= '0;
                            phase_q <= PH_QUAL;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                PH_QUAL: begin
                    if (fault) begin
                        done    <= 1'b1;
                        exc_req <= 1'b1;
                        status  <= STAT_EXC;
                        phase_q <= PH_IDLE;
                    end else if (q_q == LAST_Q) begin
                        done    <= 1'b1;
                        status  <= STAT_OK;
                        phase_q <= PH_IDLE;
                    end else begin
                        q_q <= q_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tsw_ctx_bank.sv
// Architectural context bank with per-word shadow (captured on start)
// and saved-context copy for the outgoing task.
// Assumes: restore and ld_we are never high together.
module tsw_ctx_bank #(
    parameter int CTX_WORDS = 18,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = $clog2(CTX_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        snap,
    input  logic                        save_en,
    input  logic                        restore,
    input  logic                        ld_we,
    input  logic [IDX_W-1:0]            ld_idx,
    input  logic [WORD_W-1:0]           ld_data,
    output logic [CTX_WORDS*WORD_W-1:0] ctx_flat,
    output logic [CTX_WORDS*WORD_W-1:0] save_flat
);
    for (genvar i = 0; i < CTX_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] live_q;
        logic [WORD_W-1:0] shadow_q;
        logic [WORD_W-1:0] save_q;

        // Live word: rolled back from shadow, or written by a load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q <= '0;
            end else if (restore) begin
                live_q <= shadow_q;
            end else if (ld_we && (ld_idx == IDX_W'(i))) begin
                live_q <= ld_data;
            end
        end

        // Shadow and saved copies of the live word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= '0;
                save_q   <= '0;
            end else begin
                if (snap)    shadow_q <= live_q;
                if (save_en) save_q   <= live_q;
            end
        end

        assign ctx_flat[i*WORD_W +: WORD_W]  = live_q;
        assign save_flat[i*WORD_W +: WORD_W] = save_q;
    end
endmodule

// File: rtl/tsw_tr_unit.sv
// Task register and incoming busy flag, with shadows for rollback.
// Assumes: incoming selector/descriptor are latched on the start cycle.
module tsw_tr_unit #(
    parameter int SEL_W  = 16,
    parameter int DESC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap,
    input  logic [SEL_W-1:0]  new_sel,
    input  logic [DESC_W-1:0] new_desc,
    input  logic              new_busy,
    input  logic              busy_set,
    input  logic              tr_load,
    input  logic              restore,
    output logic              busy_flag,
    output logic [SEL_W-1:0]  tr_sel,
    output logic [DESC_W-1:0] tr_desc
);
    logic [SEL_W-1:0]  in_sel_q;
    logic [DESC_W-1:0] in_desc_q;
    logic [SEL_W-1:0]  sh_sel_q;
    logic [DESC_W-1:0] sh_desc_q;
    logic              sh_busy_q;

    // Latch the incoming task and the pre-switch state on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sel_q  <= '0;
            in_desc_q <= '0;
            sh_sel_q  <= '0;
            sh_desc_q <= '0;
            sh_busy_q <= 1'b0;
        end else if (snap) begin
            in_sel_q  <= new_sel;
            in_desc_q <= new_desc;
            sh_sel_q  <= tr_sel;
            sh_desc_q <= tr_desc;
            sh_busy_q <= new_busy;
        end
    end

    // Busy flag: sampled at start, set by the busy step, rolled back on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_flag <= 1'b0;
        end else if (snap) begin
            busy_flag <= new_busy;
        end else if (restore) begin
            busy_flag <= sh_busy_q;
        end else if (busy_set) begin
            busy_flag <= 1'b1;
        end
    end

    // Task register: loaded from the latched incoming task, rolled back on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_sel  <= '0;
            tr_desc <= '0;
        end else if (restore) begin
            tr_sel  <= sh_sel_q;
            tr_desc <= sh_desc_q;
        end else if (tr_load) begin
            tr_sel  <= in_sel_q;
            tr_desc <= in_desc_q;
        end
    end
endmodule

// File: rtl/task_switch_seq.sv
// Top of the task switch commit sequencer: FSM plus context bank and
// task-register unit.
// Assumes: one 32-bit word per memory handshake, data valid with ready.
module task_switch_seq #(
    parameter int CTX_WORDS = 18,
    parameter int WORD_W    = 32,
    parameter int SEL_W     = 16,
    parameter int DESC_W    = 32,
    parameter int QUAL_CNT  = 6,
    parameter int IP_IDX    = 3,
    localparam int IDX_W    = $clog2(CTX_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [2:0]                  cause,
    input  logic [SEL_W-1:0]            new_sel,
    input  logic [DESC_W-1:0]           new_desc,
    input  logic                        new_busy,
    input  logic                        fault,
    output logic                        mem_valid,
    output logic [IDX_W-1:0]            mem_idx,
    input  logic                        mem_ready,
    input  logic [WORD_W-1:0]           mem_data,
    output logic                        running,
    output logic                        committed,
    output logic                        busy_flag,
    output logic [SEL_W-1:0]            tr_sel,
    output logic [DESC_W-1:0]           tr_desc,
    output logic [CTX_WORDS*WORD_W-1:0] ctx_out,
    output logic [CTX_WORDS*WORD_W-1:0] save_out,
    output logic                        done,
    output logic [1:0]                  status,
    output logic                        exc_req
);
    logic snap, save_en, busy_set, tr_load, ld_we, restore;

    tsw_ctrl #(.CTX_WORDS(CTX_WORDS), .QUAL_CNT(QUAL_CNT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cause(cause),
        .fault(fault), .mem_ready(mem_ready), .running(running),
        .committed(committed), .mem_valid(mem_valid), .mem_idx(mem_idx),
        .snap(snap), .save_en(save_en), .busy_set(busy_set),
        .tr_load(tr_load), .ld_we(ld_we), .restore(restore),
        .done(done), .status(status), .exc_req(exc_req)
    );

    tsw_ctx_bank #(.CTX_WORDS(CTX_WORDS), .WORD_W(WORD_W)) u_ctx (
        .clk(clk), .rst_n(rst_n), .snap(snap), .save_en(save_en),
        .restore(restore), .ld_we(ld_we), .ld_idx(mem_idx),
        .ld_data(mem_data), .ctx_flat(ctx_out), .save_flat(save_out)
    );

    tsw_tr_unit #(.SEL_W(SEL_W), .DESC_W(DESC_W)) u_tr (
        .clk(clk), .rst_n(rst_n), .snap(snap), .new_sel(new_sel),
        .new_desc(new_desc), .new_busy(new_busy), .busy_set(busy_set),
        .tr_load(tr_load), .restore(restore), .busy_flag(busy_flag),
        .tr_sel(tr_sel), .tr_desc(tr_desc)
    );

    if (IP_IDX >= CTX_WORDS) begin : g_bad_ip
        initial $error("IP_IDX out of range");
    end
endmodule

// File: rtl/tsw_checker.sv
// Protocol and sequencing properties of task_switch_seq, bound to the top.
module tsw_checker #(
    parameter int CTX_WORDS = 18,
    localparam int IDX_W    = $clog2(CTX_WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             fault,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [IDX_W-1:0] mem_idx,
    input logic             running,
    input logic             committed,
    input logic             done,
    input logic [1:0]       status,
    input logic             exc_req
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CTX_WORDS - 1);

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n) (!running && start) |=> running); // R1
    AST_IDX_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_valid) |-> (mem_idx == '0)); // R4
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && !mem_ready && !fault) |=> (mem_valid && $stable(mem_idx))); // R4
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && mem_ready && !fault && (mem_idx != LAST_IDX)) |=> (mem_valid && (mem_idx == IDX_W'($past(mem_idx) + 1'b1)))); // R4
    AST_LOAD_FAULT_CORRUPT: assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && fault) |=> (done && status == 2'd2 && !exc_req)); // R6
    AST_NO_FETCH_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) committed |-> !mem_valid); // R7
    AST_EXC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) exc_req |-> (done && status == 2'd3)); // R7
    AST_QUAL_FAULT_EXC: assert property (@(posedge clk) disable iff (!rst_n) (committed && fault) |=> exc_req); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !running); // R10
endmodule

bind task_switch_seq tsw_checker #(.CTX_WORDS(CTX_WORDS)) u_tsw_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .fault(fault),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_idx(mem_idx),
    .running(running), .committed(committed), .done(done),
    .status(status), .exc_req(exc_req)
);

// File: tb/sim_task_switch_seq.sv
module sim_task_switch_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NW  = 18;
    localparam int WW  = 32;
    localparam int IPX = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] cause = 3'd0;
    logic [15:0] new_sel = '0;
    logic [31:0] new_desc = '0;
    logic new_busy = 1'b0;
    logic fault = 1'b0;
    logic mem_valid;
    logic [4:0] mem_idx;
    logic mem_ready = 1'b0;
    logic [31:0] mem_data;
    logic running, committed, busy_flag, done, exc_req;
    logic [15:0] tr_sel;
    logic [31:0] tr_desc;
    logic [NW*WW-1:0] ctx_out, save_out;
    logic [1:0] status;
    logic [15:0] cur_sel = '0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    task_switch_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cause(cause),
        .new_sel(new_sel), .new_desc(new_desc), .new_busy(new_busy),
        .fault(fault), .mem_valid(mem_valid), .mem_idx(mem_idx),
        .mem_ready(mem_ready), .mem_data(mem_data), .running(running),
        .committed(committed), .busy_flag(busy_flag), .tr_sel(tr_sel),
        .tr_desc(tr_desc), .ctx_out(ctx_out), .save_out(save_out),
        .done(done), .status(status), .exc_req(exc_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] word_of(input logic [15:0] s, input int i);
        return {s, 16'(i * 37 + 5)};
    endfunction

    assign mem_data = word_of(cur_sel, int'(mem_idx));

    // Model of architectural state kept by the bench.
    logic [NW*WW-1:0] m_ctx = '0;
    logic [15:0] m_sel = '0;
    logic [31:0] m_desc = '0;

    task automatic chk(input bit ok, input string req, input logic [NW*WW-1:0] act, input logic [NW*WW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Steps: 0 none, 1 save, 2 busy-mark, 3 task register, 4 load word fidx, 5 qualification check fidx
    typedef struct packed {
        logic [2:0] cause;
        logic [2:0] fstep;
        logic [4:0] fidx;
        logic       stall;
        logic       busy_in;
        logic       extra;
        logic [1:0] exp_st;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 3'd0, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0},
        '{3'd1, 3'd0, 5'd0,  1'b1, 1'b0, 1'b0, 2'd0},
        '{3'd2, 3'd0, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0},
        '{3'd3, 3'd0, 5'd0,  1'b1, 1'b0, 1'b0, 2'd0},
        '{3'd4, 3'd0, 5'd0,  1'b0, 1'b1, 1'b0, 2'd0},
        '{3'd4, 3'd0, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0},
        '{3'd0, 3'd1, 5'd0,  1'b0, 1'b0, 1'b0, 2'd1},
        '{3'd1, 3'd2, 5'd0,  1'b0, 1'b0, 1'b0, 2'd1},
        '{3'd3, 3'd3, 5'd0,  1'b0, 1'b0, 1'b0, 2'd1},
        '{3'd0, 3'd4, 5'd5,  1'b0, 1'b0, 1'b0, 2'd2},
        '{3'd1, 3'd4, 5'd17, 1'b1, 1'b0, 1'b0, 2'd2},
        '{3'd2, 3'd5, 5'd0,  1'b0, 1'b0, 1'b0, 2'd3},
        '{3'd3, 3'd5, 5'd5,  1'b1, 1'b0, 1'b0, 2'd3},
        '{3'd0, 3'd0, 5'd0,  1'b0, 1'b0, 1'b1, 2'd0}
    };

    task automatic run_case(input int n, input vec_t v);
        logic [NW*WW-1:0] old_ctx = m_ctx;
        logic [NW*WW-1:0] exp_ctx;
        logic [15:0] sel = 16'h1000 + 16'(n * 16'h0111);
        logic [31:0] desc = {16'hD000, sel};
        logic exp_busy;
        int k = 0;
        int q = 0;
        bit got = 0;
        @(negedge clk);
        start = 1'b1; cause = v.cause; new_sel = sel; new_desc = desc;
        new_busy = v.busy_in; cur_sel = sel;
        @(negedge clk);
        start = 1'b0;
        while (!got && k < 500) begin
            fault = 1'b0;
            if (v.fstep >= 3'd1 && v.fstep <= 3'd3 && k == int'(v.fstep) - 1) fault = 1'b1;
            if (v.fstep == 3'd4 && mem_valid && mem_idx == v.fidx) fault = 1'b1;
            if (committed) begin
                if (v.fstep == 3'd5 && q == int'(v.fidx)) fault = 1'b1;
                q++;
            end
            mem_ready = v.stall ? ((k % 2) == 1 || (v.fstep == 3'd4 && mem_idx == v.fidx)) : 1'b1;
            if (v.extra && k == 1) begin
                start = 1'b1; new_sel = ~sel; new_desc = ~desc; cause = 3'd4;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
            if (done) got = 1;
        end
        fault = 1'b0; start = 1'b0; mem_ready = 1'b0;
        if (!got) begin
            chk(0, $sformatf("watchdog case %0d", n), 0, 1);
            return;
        end
        // Expected results (R5 abort, R6 corrupt, R7 commit).
        exp_ctx = old_ctx;
        if (v.exp_st != 2'd1) begin
            for (int i = 0; i < NW; i++)
                if (v.exp_st != 2'd2 || i < int'(v.fidx))
                    exp_ctx[i*WW +: WW] = word_of(sel, i);
        end
        exp_busy = (v.exp_st == 2'd1 || v.cause == 3'd4) ? v.busy_in : 1'b1;
        chk(status == v.exp_st, $sformatf("R5 R6 R7 status case %0d", n), status, v.exp_st);
        chk(busy_flag == exp_busy, $sformatf("R2 R5 busy case %0d", n), busy_flag, exp_busy);
        if (v.exp_st == 2'd1) begin
            chk(tr_sel == m_sel && tr_desc == m_desc, $sformatf("R5 task register restored case %0d", n), {tr_sel, tr_desc}, {m_sel, m_desc});
        end else begin
            chk(tr_sel == sel && tr_desc == desc, $sformatf("R1 R3 task register case %0d", n), {tr_sel, tr_desc}, {sel, desc});
            chk(save_out == old_ctx, $sformatf("R9 saved context case %0d", n), save_out, old_ctx);
            m_sel = sel; m_desc = desc;
        end
        chk(ctx_out == exp_ctx, $sformatf("R4 R5 R6 context case %0d", n), ctx_out, exp_ctx);
        chk(exc_req == (v.exp_st == 2'd3), $sformatf("R7 exception request case %0d", n), exc_req, v.exp_st == 2'd3);
        if (v.exp_st == 2'd3)
            chk(ctx_out[IPX*WW +: WW] == word_of(sel, IPX), $sformatf("R8 ip word case %0d", n), ctx_out[IPX*WW +: WW], word_of(sel, IPX));
        m_ctx = exp_ctx;
        @(negedge clk);
        chk(!done && !running, $sformatf("R10 done single cycle case %0d", n), {done, running}, 0);
    endtask

    initial begin : watchdog
        wait (cyc > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!running && !done && !mem_valid && !busy_flag && tr_sel == 0 && tr_desc == 0 && ctx_out == 0,
            "R11 reset state", {running, done, mem_valid, busy_flag}, 0);

        for (int n = 0; n < NV; n++) run_case(n, VECS[n]);

        // Reset in the middle of a context load (R11).
        @(negedge clk);
        start = 1'b1; cause = 3'd0; new_sel = 16'h7777; new_desc = 32'h1234_5678; cur_sel = 16'h7777;
        @(negedge clk);
        start = 1'b0; mem_ready = 1'b1;
        for (int i = 0; i < 8; i++) @(negedge clk);
        chk(mem_valid == 1'b1, "R4 load under way before reset", mem_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!running && !committed && !mem_valid && !done && !exc_req && !busy_flag &&
            tr_sel == 0 && tr_desc == 0 && ctx_out == 0, "R11 reset mid-switch",
            {running, mem_valid, busy_flag, tr_sel}, 0);
        rst_n = 1'b1; mem_ready = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule